// File: doc/BRIEF.md
# Masked I2C Slave Address Matcher

This block listens to an I2C/SMBus bus during the address phase of each transfer. After a START it shifts in seven address bits, most significant first, followed by the read/write bit. It then compares the address with a programmed slave address. Only the bit positions selected by a compare mask take part in the comparison, so one slave can answer to a whole set of addresses. A separate enable makes the block also answer to the general-call address 0x00.

When the address is accepted and hardware acknowledge is enabled, the block pulls SDA low for the ninth clock. It then reports the match with a one-cycle pulse, together with the captured read/write bit and a general-call flag. When an address is rejected, the block leaves SDA released and ignores the bus until the next START or STOP. Two byte-wide registers, one for the address and one for the mask, are written and read through a small select/write-enable port.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the address register (select 0) reads 0x00, the mask register (select 1) reads 0xFE, sda_pull is 0, and neither addr_rcvd nor match_pulse is asserted.
- R2: The address register holds the 7-bit slave address in bits 7:1 and the general-call enable in bit 0. The mask register holds the 7-bit compare mask in bits 7:1. Mask bit 0 is read/write storage and has no effect on matching. Both registers read back what was written.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a START the block samples eight bits on SCL rising edges, most significant first. The first seven bits are the address. The eighth bit is R/W and is never compared.
- R4: An address is accepted when it equals the slave address at every position where the mask holds 1. Positions where the mask holds 0 are ignored. With address 0x34, mask 0x7E accepts 0x34 and 0x35, and mask 0x7F accepts only 0x34. With address 0x70 and mask 0x73, exactly 0x70, 0x74, 0x78 and 0x7C are accepted.
- R5: With the general-call enable set, address 0x00 is accepted and the match reports match_gc=1. With the enable clear, 0x00 is accepted only when the masked compare accepts it, and match_gc is then 0.
- R6: On an accepted address, sda_pull is 1 from the SCL falling edge after the eighth bit until the SCL falling edge that ends the ninth clock. It is 0 while SCL is high for the eighth bit, and 0 again after the ninth clock.
- R7: On a rejected address sda_pull stays 0. Further bytes clocked before the next START or STOP are neither acknowledged nor reported.
- R8: After each acknowledged ninth clock, match_pulse is high for exactly one cycle. match_rw then holds the captured R/W bit and match_gc holds the general-call flag.
- R9: addr_rcvd pulses once for every complete address byte, whether or not hardware acknowledge is enabled. While ack_en is 0 at the eighth bit, sda_pull stays 0 and match_pulse does not fire.
- R10: A repeated START in the middle of an address byte discards the partial bits and starts a new capture.
- R11: A STOP in the middle of an address byte abandons the capture. Later clocks without a START produce no addr_rcvd, no acknowledge and no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| ack_en | input | 1 | Hardware address acknowledge enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 address, 1 mask |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Selected register contents |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_rcvd | output | 1 | One-cycle pulse per complete address byte |
| match_pulse | output | 1 | One-cycle pulse after an acknowledged ninth clock |
| match_rw | output | 1 | Captured R/W bit of the last match |
| match_gc | output | 1 | Last match was a general call |

## Verification
The assertions assume that SCL and SDA never change in the same synchronized cycle in a way that hides an edge. They also assume that no other device drives SDA high-to-low while the block acknowledges. In other words, START and STOP arrive only while SCL has been stable high for several cycles. The bench keeps to this: every bus phase lasts six system clocks, SDA changes only while SCL is low except at START and STOP, and the modelled line is a wired-AND of the bench master and sda_pull. Register writes happen only while the bus is idle, so the compare never sees a register change in the middle of a byte.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int AW = 7,
  parameter logic [AW-1:0] MASK_RST = '1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic        ack_en,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [AW:0] cfg_wdata,
  output logic [AW:0] cfg_rdata,
  output logic        sda_pull,
  output logic        addr_rcvd,
  output logic        match_pulse,
  output logic        match_rw,
  output logic        match_gc
);
  localparam int CW = $clog2(AW + 1);
  localparam logic [CW-1:0] LAST = CW'(AW);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WAITF, S_ACKL, S_ACKH} st_t;

  logic [AW:0]   own_r, msk_r;
  logic [2:0]    scl_sh, sda_sh;
  logic          scl_s, scl_q, sda_s, sda_q;
  logic          start_det, stop_det, scl_rise, scl_fall;
  st_t           st;
  logic [CW-1:0] bcnt;
  logic [AW-1:0] sh;
  logic          hit_q, rw_q, gc_q, en_q;
  logic          mask_hit, gc_hit, hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      own_r <= '0;
      msk_r <= {MASK_RST, 1'b0};
    end else if (cfg_we) begin
      if (cfg_sel) msk_r <= cfg_wdata;
      else         own_r <= cfg_wdata;
    end

  assign cfg_rdata = cfg_sel ? msk_r : own_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_in};
      sda_sh <= {sda_sh[1:0], sda_in};
    end

  assign scl_s     = scl_sh[1];
  assign scl_q     = scl_sh[2];
  assign sda_s     = sda_sh[1];
  assign sda_q     = sda_sh[2];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

  assign mask_hit = ((sh ^ own_r[AW:1]) & msk_r[AW:1]) == '0;
  assign gc_hit   = own_r[0] && (sh == '0);
  assign hit      = ack_en && (mask_hit || gc_hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st          <= S_IDLE;
      bcnt        <= '0;
      sh          <= '0;
      hit_q       <= 1'b0;
      rw_q        <= 1'b0;
      gc_q        <= 1'b0;
      en_q        <= 1'b0;
      addr_rcvd   <= 1'b0;
      match_pulse <= 1'b0;
      match_rw    <= 1'b0;
      match_gc    <= 1'b0;
    end else begin
      addr_rcvd   <= 1'b0;
      match_pulse <= 1'b0;
      if (start_det) begin
        st   <= S_ADDR;
        bcnt <= '0;
        sh   <= '0;
      end else if (stop_det) begin
        st <= S_IDLE;
      end else begin
        unique case (st)
          S_ADDR:
            if (scl_rise) begin
              if (bcnt == LAST) begin
                hit_q     <= hit;
                rw_q      <= sda_s;
                gc_q      <= gc_hit;
                en_q      <= ack_en;
                addr_rcvd <= 1'b1;
                st        <= S_WAITF;
              end else begin
                sh   <= {sh[AW-2:0], sda_s};
                bcnt <= bcnt + 1'b1;
              end
            end
          S_WAITF:
            if (scl_fall) st <= hit_q ? S_ACKL : S_IDLE;
          S_ACKL:
            if (scl_rise) st <= S_ACKH;
          S_ACKH:
            if (scl_fall) begin
              st          <= S_IDLE;
              match_pulse <= 1'b1;
              match_rw    <= rw_q;
              match_gc    <= gc_q;
            end
          default: ;
        endcase
      end
    end

  assign sda_pull = (st == S_ACKL) || (st == S_ACKH);

  p_pull_starts_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);
  p_pull_ends_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> (!scl_s || $past(start_det || stop_det)));
  p_pull_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> en_q);
  p_match_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);
  p_match_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(sda_pull));
  p_gc_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && match_gc) |-> own_r[0]);
  p_pulses_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_rcvd && match_pulse));
endmodule

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;
  localparam int PH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic ack_en = 1'b1, cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic sda_pull, addr_rcvd, match_pulse, match_rw, match_gc;
  logic sda_line;

  int checks = 0, failures = 0;
  int n_match = 0, n_rcvd = 0;
  logic last_rw = 1'b0, last_gc = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = sda_drv & ~sda_pull;

  i2c_addr_match dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line), .ack_en(ack_en),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sda_pull(sda_pull), .addr_rcvd(addr_rcvd), .match_pulse(match_pulse),
    .match_rw(match_rw), .match_gc(match_gc));

  always @(negedge clk) begin
    if (match_pulse) begin
      n_match++;
      last_rw = match_rw;
      last_gc = match_gc;
    end
    if (addr_rcvd) n_rcvd++;
  end

  typedef struct packed {
    logic [6:0] own; logic [6:0] msk; logic gc; logic en;
    logic [6:0] probe; logic rw; logic ack; logic gcf;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{7'h34, 7'h7F, 1'b0, 1'b1, 7'h34, 1'b0, 1'b1, 1'b0},
    '{7'h34, 7'h7F, 1'b0, 1'b1, 7'h35, 1'b0, 1'b0, 1'b0},
    '{7'h34, 7'h7F, 1'b1, 1'b1, 7'h00, 1'b0, 1'b1, 1'b1},
    '{7'h34, 7'h7F, 1'b0, 1'b1, 7'h00, 1'b0, 1'b0, 1'b0},
    '{7'h34, 7'h7E, 1'b0, 1'b1, 7'h35, 1'b1, 1'b1, 1'b0},
    '{7'h34, 7'h7E, 1'b0, 1'b1, 7'h34, 1'b1, 1'b1, 1'b0},
    '{7'h34, 7'h7E, 1'b1, 1'b1, 7'h00, 1'b1, 1'b1, 1'b1},
    '{7'h70, 7'h73, 1'b0, 1'b1, 7'h74, 1'b0, 1'b1, 1'b0},
    '{7'h70, 7'h73, 1'b0, 1'b1, 7'h78, 1'b0, 1'b1, 1'b0},
    '{7'h70, 7'h73, 1'b0, 1'b1, 7'h7C, 1'b1, 1'b1, 1'b0},
    '{7'h70, 7'h73, 1'b0, 1'b1, 7'h71, 1'b0, 1'b0, 1'b0},
    '{7'h70, 7'h73, 1'b0, 1'b1, 7'h60, 1'b0, 1'b0, 1'b0},
    '{7'h34, 7'h7F, 1'b0, 1'b0, 7'h34, 1'b0, 1'b0, 1'b0},
    '{7'h00, 7'h00, 1'b0, 1'b1, 7'h5A, 1'b1, 1'b1, 1'b0},
    '{7'h00, 7'h7F, 1'b0, 1'b1, 7'h00, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt();
    repeat (PH) @(negedge clk);
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wt();
    scl_drv = 1'b1; wt();
    sda_drv = 1'b0; wt();
    scl_drv = 1'b0; wt();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wt();
    scl_drv = 1'b1; wt();
    sda_drv = 1'b1; wt();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, output logic pull_last_high);
    pull_last_high = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wt();
      scl_drv = 1'b1; wt();
      pull_last_high = sda_pull;
      scl_drv = 1'b0; wt();
    end
  endtask

  task automatic xfer(input logic [6:0] a, input logic rw,
                      output logic ack, output logic pull_b8, output logic pull_after);
    send_bits({a, rw}, 8, pull_b8);
    sda_drv = 1'b1; wt();
    scl_drv = 1'b1; wt();
    ack = ~sda_line;
    wt();
    scl_drv = 1'b0; wt();
    pull_after = sda_pull;
  endtask

  task automatic clear_counts();
    @(negedge clk);
    n_match = 0; n_rcvd = 0; last_rw = 1'b0; last_gc = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack, pb8, pa, dummy;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    cfg_sel = 1'b0; #1;
    chk("R1 addr reg reset", cfg_rdata, 8'h00);
    cfg_sel = 1'b1; #1;
    chk("R1 mask reg reset", cfg_rdata, 8'hFE);
    chk("R1 sda_pull reset", sda_pull, 1'b0);
    chk("R1 no pulses after reset", n_match + n_rcvd, 0);

    cfg_write(1'b0, 8'h69);
    cfg_write(1'b1, 8'hFF);
    cfg_sel = 1'b0; #1;
    chk("R2 addr reg readback", cfg_rdata, 8'h69);
    cfg_sel = 1'b1; #1;
    chk("R2 mask reg readback", cfg_rdata, 8'hFF);

    for (int v = 0; v < NV; v++) begin
      cfg_write(1'b0, {VEC[v].own, VEC[v].gc});
      cfg_write(1'b1, {VEC[v].msk, 1'b1});
      ack_en = VEC[v].en;
      clear_counts();
      bus_start();
      xfer(VEC[v].probe, VEC[v].rw, ack, pb8, pa);
      bus_stop();
      wt();
      chk($sformatf("R4 vec%0d ack", v), ack, VEC[v].ack);
      chk($sformatf("R6 vec%0d no pull in bit 8", v), pb8, 1'b0);
      chk($sformatf("R6 vec%0d released after 9th", v), pa, 1'b0);
      chk($sformatf("R9 vec%0d addr_rcvd count", v), n_rcvd, 1);
      chk($sformatf("R8 vec%0d match count", v), n_match, {31'd0, VEC[v].ack});
      if (VEC[v].ack) begin
        chk($sformatf("R3 R8 vec%0d match_rw", v), last_rw, VEC[v].rw);
        chk($sformatf("R5 vec%0d match_gc", v), last_gc, VEC[v].gcf);
      end
    end

    // R4 exhaustive sweep of the 0x70 / 0x73 set
    cfg_write(1'b0, {7'h70, 1'b0});
    cfg_write(1'b1, {7'h73, 1'b0});
    ack_en = 1'b1;
    for (int a = 0; a < 128; a++) begin
      bus_start();
      xfer(7'(a), 1'b0, ack, pb8, pa);
      bus_stop();
      chk($sformatf("R4 sweep addr %0h", a), ack, ((a & 8'h73) == 8'h70) ? 1'b1 : 1'b0);
    end

    // R7: after a miss, a later byte matching the address is not acknowledged
    cfg_write(1'b0, {7'h34, 1'b0});
    cfg_write(1'b1, {7'h7F, 1'b0});
    clear_counts();
    bus_start();
    xfer(7'h22, 1'b0, ack, pb8, pa);
    chk("R7 miss nacked", ack, 1'b0);
    xfer(7'h34, 1'b0, ack, pb8, pa);
    chk("R7 later byte ignored", ack, 1'b0);
    bus_stop(); wt();
    chk("R7 rcvd count one", n_rcvd, 1);
    chk("R7 no match", n_match, 0);

    // R10: repeated start in mid address
    clear_counts();
    bus_start();
    send_bits(8'h22, 4, dummy);
    bus_start();
    xfer(7'h34, 1'b1, ack, pb8, pa);
    bus_stop(); wt();
    chk("R10 restart ack", ack, 1'b1);
    chk("R10 one addr byte", n_rcvd, 1);
    chk("R10 match rw", last_rw, 1'b1);

    // R11: stop mid address, then clocks without a start
    clear_counts();
    bus_start();
    send_bits(8'h68, 3, dummy);
    bus_stop();
    scl_drv = 1'b0; wt();
    xfer(7'h34, 1'b0, ack, pb8, pa);
    bus_stop(); wt();
    chk("R11 no ack without start", ack, 1'b0);
    chk("R11 no addr_rcvd", n_rcvd, 0);
    chk("R11 no match", n_match, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule